// File: doc/BRIEF.md
# Power-Up Strap Sampler With Clock Handoff

This block lets one device pin serve two roles. While power is coming up the pin is an input. An external pull resistor sets its level, and the block reads that level as a configuration bit. After that the pin becomes an output that carries a forwarded clock. The power-good input stands for the supply having reached its operating threshold.

While power-good is low, the block is held in reset. When power-good rises, the block keeps the pad driver off and counts a sampling window on the free-running reference clock. The window length is 2 ms by default and is derived from a reference-frequency parameter and a window-length parameter. On the final cycle of the window, the block latches the synchronized pad level into the configuration bit and raises a valid flag. The pad driver is then enabled, and the pad carries the forwarded clock.

The bit stays frozen until power-good falls. The next rise of power-good starts a fresh window.

Top module: `strap_clk_pin`

## Requirements
- R1: The window is WIN = REF_CLK_HZ/1_000_000 × WINDOW_US reference cycles. After power-good rises, `padOe` stays 0 for the first WIN reference edges and becomes 1 after edge WIN+1. The first edge leaves the idle state.
- R2: While power-good is low, `padOe`, `cfgValid` and `cfgBit` are all 0.
- R3: The bit is captured exactly once per power cycle, on the last window cycle. It takes the pad level through a two-stage synchronizer, so any level held on `padIn` for at least the final three window edges is the one captured.
- R4: `cfgValid` rises in the same cycle as `padOe`, and the two stay equal at all times.
- R5: A pad pulled low yields `cfgBit` = 0. A pad pulled high yields `cfgBit` = 1.
- R6: Once `cfgValid` is 1, no activity on `padIn` changes `cfgBit`.
- R7: Only a fall of power-good leaves the run state. The fall acts asynchronously, and the next rise restarts a full window.
- R8: `padOut` equals `fwdClk` while `padOe` is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Free-running reference clock that times the window |
| pwrGood | input | 1 | Supply-good indication; low acts as asynchronous reset |
| fwdClk | input | 1 | Clock to be driven out on the pin after sampling |
| padIn | input | 1 | Level seen at the pad |
| padOut | output | 1 | Data driven toward the pad |
| padOe | output | 1 | Pad driver enable (1 = drive) |
| cfgBit | output | 1 | Latched strap value |
| cfgValid | output | 1 | Strap value has been captured |

## Verification
The bench builds the block with REF_CLK_HZ = 1_000_000 and WINDOW_US = 8, which gives an 8-cycle window. With a window this short, every edge of the window can be checked individually for the driver enable, the valid flag and the captured bit. It also makes it cheap to repeat power cycles for both strap polarities, for a strap that changes partway through the window, for a power loss in the middle of the window, and for long toggling of the pad in the run state.

// File: rtl/strap_pkg.sv
package strap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_RUN    = 2'd2
  } strapState_e;

  typedef struct packed {
    logic cntEn;
    logic capture;
    logic drvEn;
  } strapStrb_t;
endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
(
  input  logic       refClk,
  input  logic       pwrGood,
  input  logic       lastCycle,
  output strapStrb_t strb
);
  strapState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   stateNext = ST_SAMPLE;
      ST_SAMPLE: if (lastCycle) stateNext = ST_RUN;
      ST_RUN:    stateNext = ST_RUN;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge refClk or negedge pwrGood) begin
    if (!pwrGood) state <= ST_IDLE;
    else          state <= stateNext;
  end

  always_comb begin
    strb.cntEn   = (state == ST_SAMPLE);
    strb.capture = (state == ST_SAMPLE) && lastCycle;
    strb.drvEn   = (state == ST_RUN);
  end

  AST_RUN_STICKY: assert property (@(posedge refClk) disable iff (!pwrGood)
    state == ST_RUN |=> state == ST_RUN); // R7
  AST_IDLE_BRIEF: assert property (@(posedge refClk) disable iff (!pwrGood)
    state == ST_IDLE |=> state == ST_SAMPLE); // R1
endmodule

// File: rtl/strap_dpath.sv
module strap_dpath
  import strap_pkg::*;
#(
  parameter int WIN_CYC = 16
) (
  input  logic       refClk,
  input  logic       pwrGood,
  input  strapStrb_t strb,
  input  logic       padIn,
  input  logic       fwdClk,
  output logic       lastCycle,
  output logic       padOut,
  output logic       padOe,
  output logic       cfgBit,
  output logic       cfgValid
);
  localparam int CNT_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIN_CYC - 1);

  logic [1:0]       padSync;
  logic [CNT_W-1:0] winCnt;

  initial begin
    assert (WIN_CYC >= 3)
      else $error("window must cover the synchronizer depth");
  end

  always_ff @(posedge refClk or negedge pwrGood) begin
    if (!pwrGood) padSync <= '0;
    else          padSync <= {padSync[0], padIn};
  end

  always_ff @(posedge refClk or negedge pwrGood) begin
    if (!pwrGood)        winCnt <= '0;
    else if (strb.cntEn) winCnt <= winCnt + 1'b1;
  end

  assign lastCycle = (winCnt == LAST_CNT);

  always_ff @(posedge refClk or negedge pwrGood) begin
    if (!pwrGood) begin
      cfgBit   <= 1'b0;
      cfgValid <= 1'b0;
    end else if (strb.capture) begin
      cfgBit   <= padSync[1];
      cfgValid <= 1'b1;
    end
  end

  assign padOe  = strb.drvEn;
  assign padOut = strb.drvEn & fwdClk;

  AST_CNT_BOUND: assert property (@(posedge refClk) disable iff (!pwrGood)
    winCnt <= LAST_CNT); // R1
  AST_CAPTURE_ONCE: assert property (@(posedge refClk) disable iff (!pwrGood)
    strb.capture |-> !cfgValid); // R3
  AST_BIT_FROZEN: assert property (@(posedge refClk) disable iff (!pwrGood)
    cfgValid |=> $stable(cfgBit) && cfgValid); // R6
endmodule

// File: rtl/strap_clk_pin.sv
module strap_clk_pin
  import strap_pkg::*;
#(
  parameter int REF_CLK_HZ = 50_000_000,
  parameter int WINDOW_US  = 2000
) (
  input  logic refClk,
  input  logic pwrGood,
  input  logic fwdClk,
  input  logic padIn,
  output logic padOut,
  output logic padOe,
  output logic cfgBit,
  output logic cfgValid
);
  localparam int WIN_CYC = (REF_CLK_HZ / 1_000_000) * WINDOW_US;

  strapStrb_t strb;
  logic       lastCycle;

  strap_ctrl u_ctrl (
    .refClk    (refClk),
    .pwrGood   (pwrGood),
    .lastCycle (lastCycle),
    .strb      (strb)
  );

  strap_dpath #(.WIN_CYC(WIN_CYC)) u_dpath (
    .refClk    (refClk),
    .pwrGood   (pwrGood),
    .strb      (strb),
    .padIn     (padIn),
    .fwdClk    (fwdClk),
    .lastCycle (lastCycle),
    .padOut    (padOut),
    .padOe     (padOe),
    .cfgBit    (cfgBit),
    .cfgValid  (cfgValid)
  );

  AST_OE_WITH_VALID: assert property (@(posedge refClk) disable iff (!pwrGood)
    padOe == cfgValid); // R4
  AST_DRIVE_GATED: assert property (@(posedge refClk) disable iff (!pwrGood)
    !padOe |-> !padOut); // R8
endmodule

// File: tb/sim_strap_clk_pin.sv
module sim_strap_clk_pin;
  localparam int REF_HZ = 1_000_000;
  localparam int WIN_US = 8;
  localparam int WIN    = (REF_HZ / 1_000_000) * WIN_US;

  logic refClk = 0, pwrGood = 0, fwdClk = 0, strap = 0;
  logic padOut, padOe, cfgBit, cfgValid;
  wire  padIn = padOe ? padOut : strap;
  int   nRun = 0, nFail = 0;
  bit   done = 0;

  always #10 refClk = ~refClk;
  always #17 fwdClk = ~fwdClk;

  strap_clk_pin #(.REF_CLK_HZ(REF_HZ), .WINDOW_US(WIN_US)) u0 (
    .refClk(refClk), .pwrGood(pwrGood), .fwdClk(fwdClk), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .cfgBit(cfgBit), .cfgValid(cfgValid));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edgeN(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge refClk);
      @(negedge refClk);
    end
  endtask

  // Power up, walk the window edge by edge; strapMid changes strap at edge chgAt (0 = none)
  task automatic powerCycle(input logic s0, input logic s1, input int chgAt);
    logic expBit;
    @(negedge refClk);
    pwrGood = 0;
    strap = s0;
    #1;
    chk(padOe == 0 && cfgValid == 0 && cfgBit == 0, "R2", {padOe, cfgValid, cfgBit}, 0);
    edgeN(2);
    pwrGood = 1;
    for (int k = 1; k <= WIN + 1; k++) begin
      if (k == chgAt) strap = s1;
      edgeN(1);
      chk(padOe == (k == WIN + 1), "R1", padOe, k == WIN + 1);
      chk(cfgValid == padOe, "R4", cfgValid, padOe);
      if (k <= WIN) chk(padOut == 0, "R8", padOut, 0);
    end
    // level on the last three window edges (edges WIN-1..WIN+1) is what is captured
    expBit = (chgAt != 0 && chgAt <= WIN - 1) ? s1 : s0;
    chk(cfgBit == expBit, (s0 == s1) ? "R5" : "R3", cfgBit, expBit);
  endtask

  task automatic runToggle(input logic expBit);
    for (int i = 0; i < 40; i++) begin
      strap = ~strap;
      edgeN(1);
      chk(cfgBit == expBit && cfgValid, "R6", cfgBit, expBit);
      chk(padOut == fwdClk, "R8", padOut, fwdClk);
    end
    chk(padOe == 1, "R7", padOe, 1);
  endtask

  initial begin
    #5000000;
    nRun++; nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    edgeN(3);
    chk(padOe == 0 && cfgValid == 0 && cfgBit == 0, "R2", padOe, 0);
    powerCycle(1'b0, 1'b0, 0); runToggle(1'b0);   // R5 low strap
    powerCycle(1'b1, 1'b1, 0); runToggle(1'b1);   // R5 high strap
    for (int c = 2; c <= WIN + 1; c++) begin       // R3 mid-window strap change
      powerCycle(1'b0, 1'b1, c);
      powerCycle(1'b1, 1'b0, c);
    end
    // R7 power loss mid-window then full restart
    @(negedge refClk); pwrGood = 0; strap = 1; edgeN(1); pwrGood = 1;
    edgeN(WIN / 2);
    pwrGood = 0; #1;
    chk(padOe == 0 && cfgValid == 0, "R7", padOe, 0);
    edgeN(1); pwrGood = 1;
    edgeN(WIN);
    chk(padOe == 0, "R7", padOe, 0);
    edgeN(1);
    chk(padOe == 1 && cfgBit == 1, "R7", cfgBit, 1);
    // R7 power loss in run clears state
    pwrGood = 0; #1;
    chk(cfgBit == 0 && cfgValid == 0 && padOe == 0, "R7", cfgBit, 0);
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    done = 1;
    $finish;
  end
endmodule